// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the processor reset and the watchdog timeout for a supply supervisor. Three conditions start a reset: power-up (the asynchronous `rst_n`), a primary low-supply flag from an external comparator, and a manual-reset button once it has been debounced. A watchdog expiry also starts one. All of them feed a single reset stretcher. The stretcher keeps reset active while any condition is present. Once every condition has cleared, it holds reset for a timeout chosen by a 2-bit code, and then releases it.

A watchdog counts millisecond ticks from its last restart. Every edge of the kick input restarts it, in either direction. When it expires it pulses `wdt_to` for one clock and starts a reset stretch. While reset is active the watchdog counter is held cleared, and it is also held cleared while the interval code selects "off". A second supply flag drives its own fail output and never resets the processor. Time comes from an internal tick that divides the clock by `CLKS_PER_MS`. All inputs are taken to be synchronous to `clk`.

The reset stretcher runs through three states:
- `RS_HOLD`: a condition is present.
- `RS_STRETCH`: the timeout is being counted.
- `RS_RUN`: the processor is running.

Its transitions:
- hold_to_stretch: every condition has cleared.
- stretch_done: the timeout has elapsed, so the block enters run.
- any_to_hold: a condition has appeared.
- wdt_restretch: a watchdog expiry sends run back to stretch.

The debouncer runs through `MR_UP`, `MR_FILTER` and `MR_DOWN`:
- press_seen: from up to filter.
- filter_pass: from filter to down, after enough consecutive low ticks.
- bounce: from filter back to up.
- release: from down back to up.

The watchdog has two states, `WD_PARK` and `WD_COUNT`:
- unpark: from park to count, when neither reset nor the disable code is present.
- park: from count to park, when either of them is present.

Top module: `supv_reset_wdt`

## Requirements
- R1: `reset_hi` is 1 while `rst_n` is low, and from the clock after `low_vcc` is seen high for as long as `low_vcc` stays high. Reset never releases in the clock after `low_vcc` was high.
- R2: `reset_n` is always the inverse of `reset_hi`.
- R3: Once all reset conditions have cleared, reset stays active for the timeout that `rto_code` selects: 00 = 50 ms, 01 = 200 ms, 10 = 400 ms, 11 = 800 ms.
- R4: `mr_n` counts as pressed only after it has been low for 16 consecutive ticks, and a shorter or interrupted low has no effect on reset. A press holds reset active, and its release starts the same stretch as a supply reset.
- R5: The watchdog expires a set time after its last restart, chosen by `wdt_code`: 00 = 1400 ms, 01 = 200 ms, 10 = 25 ms. On expiry `wdt_to` is high for exactly one clock, and reset becomes active on the next clock.
- R6: With `wdt_code` = 11 the watchdog is disabled and `wdt_to` stays 0.
- R7: Every change of `kick` restarts the watchdog interval, rising and falling edges alike.
- R8: The watchdog counter is held cleared while reset is active. No expiry happens during reset, and the first expiry after reset ends comes a full interval later.
- R9: A change of `rto_code` takes effect at the start of the next stretch. A change of `wdt_code` between enabled intervals takes effect at the next watchdog restart, which is a kick, an expiry or the end of a hold.
- R10: `v2_fail` follows `v2_low` one clock later and has no effect on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| low_vcc | input | 1 | Primary supply below threshold, active high |
| v2_low | input | 1 | Secondary supply below threshold, active high |
| mr_n | input | 1 | Raw manual-reset button, active low |
| kick | input | 1 | Watchdog kick; any edge restarts the interval |
| rto_code | input | 2 | Reset timeout select |
| wdt_code | input | 2 | Watchdog interval select, 11 = off |
| reset_hi | output | 1 | Processor reset, active high |
| reset_n | output | 1 | Processor reset, active low |
| wdt_to | output | 1 | One-clock watchdog expiry pulse |
| v2_fail | output | 1 | Secondary supply fail flag |

## Verification
The assertions check, on every cycle, these relations:
- the two reset polarities are exact inverses;
- a low-supply flag forces reset on the next clock and blocks its release;
- a watchdog pulse lasts one clock and is followed by reset;
- no expiry occurs while reset is active or while the disable code is present;
- the secondary fail flag tracks its input.

The lengths of intervals can only be shown by the bench's scenarios. These are the stretch time for each timeout code, the expiry time for each interval code, and the 16-tick debounce window with its rejection of short or broken presses. The same holds for the timing of configuration changes, which take effect at a restart, and for restarts on both edges of the kick.

// File: rtl/srw_pkg.sv
package srw_pkg;

    typedef enum logic [1:0] {
        RS_HOLD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        MR_UP     = 2'd0,
        MR_FILTER = 2'd1,
        MR_DOWN   = 2'd2
    } mr_state_e;

    typedef enum logic {
        WD_PARK  = 1'b0,
        WD_COUNT = 1'b1
    } wd_state_e;

endpackage

// File: rtl/srw_tick.sv
module srw_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLKS_PER_MS - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    always_comb tick = (div_q == LAST);
endmodule

// File: rtl/srw_mr_filter.sv
module srw_mr_filter
    import srw_pkg::*;
#(
    parameter int DB_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic mr_n,
    output logic mr_held
);
    localparam int DW = $clog2(DB_TICKS + 1);
    localparam logic [DW-1:0] LAST = DW'(DB_TICKS - 1);

    mr_state_e     st_q, st_d;
    logic [DW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            MR_UP: begin
                cnt_d = '0;
                if (!mr_n) st_d = MR_FILTER;            // press_seen
            end
            MR_FILTER: begin
                if (mr_n) begin
                    st_d  = MR_UP;                      // bounce
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) st_d = MR_DOWN;  // filter_pass
                    else               cnt_d = cnt_q + 1'b1;
                end
            end
            MR_DOWN: begin
                if (mr_n) begin
                    st_d  = MR_UP;                      // release
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = MR_UP;
                cnt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MR_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb mr_held = (st_q == MR_DOWN);
endmodule

// File: rtl/srw_reset_ctl.sv
module srw_reset_ctl
    import srw_pkg::*;
#(
    parameter int RTO_MS0 = 50,
    parameter int RTO_MS1 = 200,
    parameter int RTO_MS2 = 400,
    parameter int RTO_MS3 = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       low_vcc,
    input  logic       mr_held,
    input  logic       wdt_to,
    input  logic [1:0] rto_code,
    output logic       rst_active
);
    localparam int M01  = (RTO_MS0 > RTO_MS1) ? RTO_MS0 : RTO_MS1;
    localparam int M23  = (RTO_MS2 > RTO_MS3) ? RTO_MS2 : RTO_MS3;
    localparam int RMAX = (M01 > M23) ? M01 : M23;
    localparam int CW   = $clog2(RMAX + 1);

    function automatic logic [CW-1:0] len_of(input logic [1:0] c);
        unique case (c)
            2'b00:   len_of = CW'(RTO_MS0);
            2'b01:   len_of = CW'(RTO_MS1);
            2'b10:   len_of = CW'(RTO_MS2);
            default: len_of = CW'(RTO_MS3);
        endcase
    endfunction

    rst_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] len_q, len_d;
    logic          cond;

    always_comb cond = low_vcc | mr_held;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        len_d = len_q;
        unique case (st_q)
            RS_HOLD: begin
                if (!cond) begin                        // hold_to_stretch
                    st_d  = RS_STRETCH;
                    cnt_d = '0;
                    len_d = len_of(rto_code);
                end
            end
            RS_STRETCH: begin
                if (cond) begin
                    st_d = RS_HOLD;                     // any_to_hold
                end else if (tick) begin
                    if (cnt_q == len_q - 1'b1) st_d = RS_RUN;   // stretch_done
                    else                       cnt_d = cnt_q + 1'b1;
                end
            end
            RS_RUN: begin
                if (cond) begin
                    st_d = RS_HOLD;                     // any_to_hold
                end else if (wdt_to) begin              // wdt_restretch
                    st_d  = RS_STRETCH;
                    cnt_d = '0;
                    len_d = len_of(rto_code);
                end
            end
            default: st_d = RS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_HOLD;
            cnt_q <= '0;
            len_q <= len_of(2'b00);
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            len_q <= len_d;
        end
    end

    always_comb rst_active = (st_q != RS_RUN);
endmodule

// File: rtl/srw_watchdog.sv
module srw_watchdog
    import srw_pkg::*;
#(
    parameter int WDT_MS0 = 1400,
    parameter int WDT_MS1 = 200,
    parameter int WDT_MS2 = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold_rst,
    input  logic [1:0] wdt_code,
    input  logic       kick,
    output logic       wdt_to
);
    localparam int M01  = (WDT_MS0 > WDT_MS1) ? WDT_MS0 : WDT_MS1;
    localparam int WMAX = (M01 > WDT_MS2) ? M01 : WDT_MS2;
    localparam int CW   = $clog2(WMAX + 1);

    function automatic logic [CW-1:0] lim_of(input logic [1:0] c);
        unique case (c)
            2'b01:   lim_of = CW'(WDT_MS1);
            2'b10:   lim_of = CW'(WDT_MS2);
            default: lim_of = CW'(WDT_MS0);
        endcase
    endfunction

    wd_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lim_q, lim_d;
    logic          kick_q, kick_edge, park, fire;

    always_comb kick_edge = kick ^ kick_q;
    always_comb park      = hold_rst | (wdt_code == 2'b11);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        fire  = 1'b0;
        unique case (st_q)
            WD_PARK: begin
                cnt_d = '0;
                lim_d = lim_of(wdt_code);
                if (!park) st_d = WD_COUNT;             // unpark
            end
            WD_COUNT: begin
                if (park) begin
                    st_d  = WD_PARK;                    // park
                    cnt_d = '0;
                end else if (kick_edge) begin
                    cnt_d = '0;
                    lim_d = lim_of(wdt_code);
                end else if (tick) begin
                    if (cnt_q == lim_q - 1'b1) begin
                        fire  = 1'b1;
                        cnt_d = '0;
                        lim_d = lim_of(wdt_code);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = WD_PARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WD_PARK;
            cnt_q  <= '0;
            lim_q  <= lim_of(2'b00);
            kick_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            lim_q  <= lim_d;
            kick_q <= kick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_to <= 1'b0;
        else        wdt_to <= fire;
    end
endmodule

// File: rtl/supv_reset_wdt.sv
module supv_reset_wdt #(
    parameter int CLKS_PER_MS = 50000,
    parameter int DB_TICKS    = 16,
    parameter int RTO_MS0     = 50,
    parameter int RTO_MS1     = 200,
    parameter int RTO_MS2     = 400,
    parameter int RTO_MS3     = 800,
    parameter int WDT_MS0     = 1400,
    parameter int WDT_MS1     = 200,
    parameter int WDT_MS2     = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_vcc,
    input  logic       v2_low,
    input  logic       mr_n,
    input  logic       kick,
    input  logic [1:0] rto_code,
    input  logic [1:0] wdt_code,
    output logic       reset_hi,
    output logic       reset_n,
    output logic       wdt_to,
    output logic       v2_fail
);
    logic tick, mr_held, rst_active;

    srw_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    srw_mr_filter #(.DB_TICKS(DB_TICKS)) u_mr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mr_n(mr_n), .mr_held(mr_held)
    );

    srw_reset_ctl #(
        .RTO_MS0(RTO_MS0), .RTO_MS1(RTO_MS1), .RTO_MS2(RTO_MS2), .RTO_MS3(RTO_MS3)
    ) u_rst (
        .clk(clk), .rst_n(rst_n), .tick(tick), .low_vcc(low_vcc),
        .mr_held(mr_held), .wdt_to(wdt_to), .rto_code(rto_code),
        .rst_active(rst_active)
    );

    srw_watchdog #(
        .WDT_MS0(WDT_MS0), .WDT_MS1(WDT_MS1), .WDT_MS2(WDT_MS2)
    ) u_wdt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold_rst(rst_active),
        .wdt_code(wdt_code), .kick(kick), .wdt_to(wdt_to)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v2_fail <= 1'b0;
        else        v2_fail <= v2_low;
    end

    always_comb begin
        reset_hi = rst_active;
        reset_n  = ~rst_active;
    end
endmodule

// File: rtl/supv_reset_wdt_chk.sv
module supv_reset_wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       low_vcc,
    input logic       v2_low,
    input logic [1:0] wdt_code,
    input logic       reset_hi,
    input logic       reset_n,
    input logic       wdt_to,
    input logic       v2_fail
);
    always_comb begin
        if (rst_n) begin
            assert_polarity_R2: assert (reset_n == !reset_hi)
                else $error("reset polarities disagree");
        end
    end

    assert_lowvcc_forces_R1: assert property (@(posedge clk) disable iff (!rst_n)
        low_vcc |=> reset_hi);

    assert_no_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_hi) |-> !$past(low_vcc));

    assert_pulse_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to |=> !wdt_to);

    assert_pulse_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_to |=> reset_hi);

    assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_code == 2'b11) |=> !wdt_to);

    assert_held_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reset_hi) |-> !wdt_to);

    assert_v2_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        v2_low |=> v2_fail);

    assert_v2_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !v2_low |=> !v2_fail);
endmodule

bind supv_reset_wdt supv_reset_wdt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .low_vcc(low_vcc), .v2_low(v2_low),
    .wdt_code(wdt_code), .reset_hi(reset_hi), .reset_n(reset_n),
    .wdt_to(wdt_to), .v2_fail(v2_fail)
);

// File: tb/supv_reset_wdt_tb.sv
module supv_reset_wdt_tb;
    localparam int C = 4;           // clocks per ms tick in this bench
    localparam int NV = 7;

    typedef struct packed {
        logic        kind;          // 0 = reset timeout, 1 = watchdog interval
        logic [1:0]  code;
        logic [15:0] ms;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 16'd50},
        '{1'b0, 2'b01, 16'd200},
        '{1'b0, 2'b10, 16'd400},
        '{1'b0, 2'b11, 16'd800},
        '{1'b1, 2'b10, 16'd25},
        '{1'b1, 2'b01, 16'd200},
        '{1'b1, 2'b00, 16'd1400}
    };

    logic clk = 1'b0, rst_n = 1'b0, low_vcc = 1'b0, v2_low = 1'b0;
    logic mr_n = 1'b1, kick = 1'b0;
    logic [1:0] rto_code = 2'b00, wdt_code = 2'b11;
    logic reset_hi, reset_n, wdt_to, v2_fail;

    int tests = 0, fails = 0, pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;      // 50 MHz

    supv_reset_wdt #(.CLKS_PER_MS(C)) u_dut (
        .clk(clk), .rst_n(rst_n), .low_vcc(low_vcc), .v2_low(v2_low),
        .mr_n(mr_n), .kick(kick), .rto_code(rto_code), .wdt_code(wdt_code),
        .reset_hi(reset_hi), .reset_n(reset_n), .wdt_to(wdt_to), .v2_fail(v2_fail)
    );

    always @(posedge clk) if (wdt_to) pulses <= pulses + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ms(input int ms);
        repeat (ms * C) @(negedge clk);
    endtask

    task automatic until_release(output int n);
        n = 0;
        while (reset_hi && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic until_pulse(output int n);
        int p0;
        p0 = pulses;
        n = 0;
        while (pulses == p0 && n < 20000) begin @(negedge clk); n++; end
    endtask

    function automatic bit near(input int n, input int ms);
        return (n >= (ms - 1) * C) && (n <= (ms + 1) * C + 4);
    endfunction

    initial begin
        int n, p0;
        repeat (3) @(negedge clk);
        check(reset_hi == 1'b1, "R1 reset_hi in power-on", reset_hi, 1);
        check(reset_n == 1'b0, "R2 reset_n in power-on", reset_n, 0);
        check(wdt_to == 1'b0, "R5 wdt_to in power-on", wdt_to, 0);
        rst_n = 1'b1;
        until_release(n);
        check(near(n, 50), "R3 power-up stretch", n, 50 * C);
        check(reset_n == 1'b1, "R2 reset_n when running", reset_n, 1);

        // vector table: reset timeouts and watchdog intervals
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == 1'b0) begin
                rto_code = VECS[i].code;
                @(negedge clk); low_vcc = 1'b1;
                repeat (5) @(negedge clk);
                check(reset_hi == 1'b1, "R1 low_vcc holds reset", reset_hi, 1);
                low_vcc = 1'b0;
                until_release(n);
                check(near(n, int'(VECS[i].ms)), "R3 stretch length", n, int'(VECS[i].ms) * C);
            end else begin
                rto_code = 2'b00;
                wdt_code = VECS[i].code;
                @(negedge clk); kick = ~kick;
                until_pulse(n);
                check(near(n, int'(VECS[i].ms)), "R5 watchdog interval", n, int'(VECS[i].ms) * C);
                check(reset_hi == 1'b1, "R5 expiry starts reset", reset_hi, 1);
                wdt_code = 2'b11;
                until_release(n);
                check(near(n, 50), "R5 expiry stretch", n, 50 * C);
            end
        end

        // R6: disabled watchdog never fires
        p0 = pulses;
        wait_ms(1600);
        check(pulses == p0, "R6 disabled no pulse", pulses - p0, 0);
        check(reset_hi == 1'b0, "R6 disabled no reset", reset_hi, 0);

        // R8: counter held during reset
        low_vcc = 1'b1;
        repeat (5) @(negedge clk);
        wdt_code = 2'b10;
        repeat (5) @(negedge clk);
        low_vcc = 1'b0;
        p0 = pulses;
        until_release(n);
        check(pulses == p0, "R8 no expiry during reset", pulses - p0, 0);
        until_pulse(n);
        check(near(n, 25), "R8 full interval after reset", n, 25 * C);
        wdt_code = 2'b11;
        until_release(n);

        // R7: both kick edges restart
        wdt_code = 2'b01;
        p0 = pulses;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); kick = ~kick;
            wait_ms(150);
        end
        check(pulses == p0, "R7 kicks on both edges keep alive", pulses - p0, 0);
        @(negedge clk); kick = ~kick;
        until_pulse(n);
        check(near(n, 200), "R7 expiry after last kick", n, 200 * C);
        wdt_code = 2'b11;
        until_release(n);

        // R9: watchdog code change waits for a restart
        wdt_code = 2'b00;
        @(negedge clk); kick = ~kick;
        wait_ms(5);
        wdt_code = 2'b10;
        p0 = pulses;
        wait_ms(200);
        check(pulses == p0, "R9 new interval not yet applied", pulses - p0, 0);
        kick = ~kick;
        until_pulse(n);
        check(near(n, 25), "R9 new interval after kick", n, 25 * C);
        wdt_code = 2'b11;
        until_release(n);

        // R9: timeout code change during a stretch is deferred
        rto_code = 2'b00;
        low_vcc = 1'b1;
        repeat (5) @(negedge clk);
        low_vcc = 1'b0;
        wait_ms(10);
        rto_code = 2'b11;
        until_release(n);
        check(near(n + 10 * C, 50), "R9 stretch keeps latched code", n + 10 * C, 50 * C);
        rto_code = 2'b00;

        // R4: manual reset debounce
        mr_n = 1'b0; wait_ms(10); mr_n = 1'b1; wait_ms(2);
        check(reset_hi == 1'b0, "R4 short press ignored", reset_hi, 1'b0);
        mr_n = 1'b0; wait_ms(10); mr_n = 1'b1; wait_ms(1);
        mr_n = 1'b0; wait_ms(10);
        check(reset_hi == 1'b0, "R4 broken press ignored", reset_hi, 1'b0);
        mr_n = 1'b1; wait_ms(2);
        check(reset_hi == 1'b0, "R4 after broken press", reset_hi, 1'b0);
        mr_n = 1'b0; wait_ms(14);
        check(reset_hi == 1'b0, "R4 not before 16 ticks", reset_hi, 1'b0);
        wait_ms(16);
        check(reset_hi == 1'b1, "R4 long press resets", reset_hi, 1);
        mr_n = 1'b1;
        until_release(n);
        check(near(n, 50), "R4 stretch after release", n, 50 * C);

        // R10: secondary fail
        v2_low = 1'b1;
        repeat (3) @(negedge clk);
        check(v2_fail == 1'b1, "R10 v2_fail raised", v2_fail, 1);
        check(reset_hi == 1'b0, "R10 no reset from v2", reset_hi, 0);
        v2_low = 1'b0;
        repeat (2) @(negedge clk);
        check(v2_fail == 1'b0, "R10 v2_fail cleared", v2_fail, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule